// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block sits inside an interrupt distributor and turns one 32-bit write to its software-interrupt register into pending requests on a set of CPUs. The write carries three things:

- an interrupt number from 0 to 15;
- a filter selector that picks how the targets are chosen;
- an explicit CPU bitmask, which only some selector values use.

The requesting CPU is given by a separate index input.

For each chosen target, the block does three things one clock after the write:

- it raises a one-cycle set pulse for that CPU;
- it marks the interrupt pending for that CPU;
- it records which CPU sent it.

A clear port removes one pending entry. The clear only acts when the source it names matches the recorded one. This lets a consumer retire a request it has taken. When the block is built for a single CPU, the requester index is always treated as 0.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every set pulse, every pending bit, every recorded source and the reported interrupt number are 0.
- R2: The interrupt number is write-data bits [3:0] alone; bits [9:4] never change which interrupt is raised or reported on `sgi_id`.
- R3: With selector bits [25:24] = 0, the targets are write-data bits [23:16] ANDed with the set of implemented CPUs (bit i is CPU i).
- R4: With selector = 1, the targets are every implemented CPU except the requester.
- R5: With selector = 2, the only target is the requester, and only if its index is an implemented CPU.
- R6: With selector = 3, a write raises nothing and leaves all state unchanged.
- R7: One clock after an accepted write, `set_pulse` holds exactly the target mask for one cycle and `sgi_id` shows the interrupt number. For each target, the pending bit at index cpu*16+sgi is set, and the source field at bits [(cpu*16+sgi)*3 +: 3] holds the requester.
- R8: A write whose final target mask is empty changes nothing, including `sgi_id`.
- R9: With NCPU = 1, the requester index input is ignored and 0 is used as both requester and recorded source.
- R10: A clear with `clr_en` removes the pending bit for (`clr_cpu`, `clr_sgi`) only when the recorded source equals `clr_src`. It has no effect otherwise, or when `clr_cpu` is not implemented. A set of the same entry in the same cycle wins over the clear.
- R11: In a cycle with no write, `set_pulse` is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the software-interrupt register |
| wr_data | input | 32 | Written word: [3:0] number, [23:16] CPU mask, [25:24] selector |
| req_cpu | input | 3 | Index of the CPU performing the write |
| clr_en | input | 1 | Clear request strobe |
| clr_cpu | input | 3 | CPU whose pending entry is cleared |
| clr_sgi | input | 4 | Interrupt number to clear |
| clr_src | input | 3 | Source that must match the recorded one |
| set_pulse | output | NCPU | One-cycle pending-set pulse per CPU |
| sgi_id | output | 4 | Number of the most recently raised interrupt |
| pend | output | NCPU*16 | Pending bits, index cpu*16+sgi |
| src_tbl | output | NCPU*48 | Recorded source per entry, 3 bits each |

## Verification
All results are due exactly one clock after the write or clear that causes them: the set pulse, the interrupt number, the pending bits and the source table. The pulse falls again on the clock after that. The bench applies each stimulus just after a falling edge and removes it on the next falling edge. It samples every output at that same falling edge, which lies half a period after the one rising edge that registers the result. A 4-CPU and a 1-CPU instance see the same stimulus, so dropped target bits and the forced requester are checked in the same cycle as the normal case.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  input  logic [2:0]           req_cpu,
  input  logic                 clr_en,
  input  logic [2:0]           clr_cpu,
  input  logic [3:0]           clr_sgi,
  input  logic [2:0]           clr_src,
  output logic [NCPU-1:0]      set_pulse,
  output logic [3:0]           sgi_id,
  output logic [NCPU*16-1:0]   pend,
  output logic [NCPU*48-1:0]   src_tbl
);
  localparam int NS = 16;
  localparam int SW = 3;
  localparam logic [7:0] IMPL = 8'((9'd1 << NCPU) - 9'd1);

  logic [2:0] req_eff;
  generate
    if (NCPU == 1) begin : g_single
      assign req_eff = 3'd0;
    end else begin : g_multi
      assign req_eff = req_cpu;
    end
  endgenerate

  wire [7:0] self_bit = 8'd1 << req_eff;
  wire [3:0] num      = wr_data[3:0];

  logic [7:0] tgt;
  always_comb begin
    case (wr_data[25:24])
      2'd0:    tgt = wr_data[23:16] & IMPL;
      2'd1:    tgt = IMPL & ~self_bit;
      2'd2:    tgt = IMPL & self_bit;
      default: tgt = 8'd0;
    endcase
  end

  wire [7:0]      hit8 = wr_en ? tgt : 8'd0;
  wire [NCPU-1:0] hit  = hit8[NCPU-1:0];

  wire unused_bits = ^{wr_data[31:26], wr_data[15:4], hit8, req_cpu};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_pulse <= '0;
      sgi_id    <= '0;
      pend      <= '0;
      src_tbl   <= '0;
    end else begin
      set_pulse <= hit;
      if (|hit) sgi_id <= num;
      for (int c = 0; c < NCPU; c++) begin
        for (int s = 0; s < NS; s++) begin
          if (hit[c] && num == 4'(s)) begin
            pend[c*NS+s]               <= 1'b1;
            src_tbl[(c*NS+s)*SW +: SW] <= req_eff;
          end else if (clr_en && clr_cpu == 3'(c) && clr_sgi == 4'(s) &&
                       src_tbl[(c*NS+s)*SW +: SW] == clr_src) begin
            pend[c*NS+s] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [2:0]         req_cpu,
  input logic [NCPU-1:0]    set_pulse,
  input logic [3:0]         sgi_id,
  input logic [NCPU*16-1:0] pend
);
  a_r11_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> set_pulse == '0);

  a_r6_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd3) |=> set_pulse == '0);

  a_r2_id_from_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (set_pulse == '0 || sgi_id == $past(wr_data[3:0])));

  a_r3_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd0) |=>
      (8'(set_pulse) & ~$past(wr_data[23:16])) == 8'd0);

  a_r4_requester_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd1) |=>
      (8'(set_pulse) & (8'd1 << $past(req_cpu))) == 8'd0);

  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd2) |=> $countones(set_pulse) <= 1);

  a_r7_pulse_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse[0] |-> pend[sgi_id]);

  generate
    if (NCPU == 1) begin : g_one
      a_r9_self_is_cpu0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd2) |=> set_pulse[0]);
    end
  endgenerate
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .req_cpu(req_cpu),
  .set_pulse(set_pulse), .sgi_id(sgi_id), .pend(pend)
);

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0] req_cpu = '0;
  logic clr_en = 1'b0;
  logic [2:0] clr_cpu = '0;
  logic [3:0] clr_sgi = '0;
  logic [2:0] clr_src = '0;

  logic [3:0]   pulse0;
  logic [3:0]   id0;
  logic [63:0]  pend0;
  logic [191:0] src0;
  logic [0:0]   pulse1;
  logic [3:0]   id1;
  logic [15:0]  pend1;
  logic [47:0]  src1;

  always #10 clk = ~clk;

  sgi_dispatch #(.NCPU(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .req_cpu(req_cpu),
    .clr_en(clr_en), .clr_cpu(clr_cpu), .clr_sgi(clr_sgi), .clr_src(clr_src),
    .set_pulse(pulse0), .sgi_id(id0), .pend(pend0), .src_tbl(src0));

  sgi_dispatch #(.NCPU(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .req_cpu(req_cpu),
    .clr_en(clr_en), .clr_cpu(clr_cpu), .clr_sgi(clr_sgi), .clr_src(clr_src),
    .set_pulse(pulse1), .sgi_id(id1), .pend(pend1), .src_tbl(src1));

  int errs = 0;
  int checks = 0;
  int ncpu_of [2] = '{4, 1};
  logic       exp_p [2][8][16];
  logic [2:0] exp_s [2][8][16];
  logic [3:0] exp_id [2];

  task automatic chk(bit ok, string tag, string what, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(int n, logic [31:0] d, logic [2:0] r);
    logic [7:0] impl = 8'((9'd1 << n) - 9'd1);
    logic [2:0] re = (n == 1) ? 3'd0 : r;
    logic [7:0] sb = 8'd1 << re;
    case (d[25:24])
      2'd0:    return d[23:16] & impl;
      2'd1:    return impl & ~sb;
      2'd2:    return impl & sb;
      default: return 8'd0;
    endcase
  endfunction

  task automatic compare_all(logic [7:0] m0, logic [7:0] m1, string tag);
    logic [63:0]  ep0 = '0;
    logic [191:0] es0 = '0;
    logic [15:0]  ep1 = '0;
    logic [47:0]  es1 = '0;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 16; s++) begin
        ep0[c*16+s] = exp_p[0][c][s];
        es0[(c*16+s)*3 +: 3] = exp_s[0][c][s];
      end
    for (int s = 0; s < 16; s++) begin
      ep1[s] = exp_p[1][0][s];
      es1[s*3 +: 3] = exp_s[1][0][s];
    end
    chk(pulse0 == m0[3:0], tag, "pulse 4cpu", 192'(pulse0), 192'(m0[3:0]));
    chk(pulse1 == m1[0:0], tag, "pulse 1cpu", 192'(pulse1), 192'(m1[0:0]));
    chk(id0 == exp_id[0], tag, "sgi_id 4cpu", 192'(id0), 192'(exp_id[0]));
    chk(id1 == exp_id[1], tag, "sgi_id 1cpu", 192'(id1), 192'(exp_id[1]));
    chk(pend0 == ep0, tag, "pend 4cpu", 192'(pend0), 192'(ep0));
    chk(src0 == es0, tag, "src 4cpu", src0, es0);
    chk(pend1 == ep1, tag, "pend 1cpu", 192'(pend1), 192'(ep1));
    chk(src1 == es1, tag, "src 1cpu", 192'(src1), 192'(es1));
  endtask

  task automatic step(bit we, logic [31:0] d, logic [2:0] r, bit ce,
                      logic [2:0] cc, logic [3:0] cs, logic [2:0] csr, string tag);
    logic [7:0] m [2];
    @(negedge clk);
    wr_en = we; wr_data = d; req_cpu = r;
    clr_en = ce; clr_cpu = cc; clr_sgi = cs; clr_src = csr;
    for (int k = 0; k < 2; k++) begin
      int n = ncpu_of[k];
      logic [2:0] re = (n == 1) ? 3'd0 : r;
      m[k] = we ? exp_mask(n, d, r) : 8'd0;
      if (m[k] != 8'd0) exp_id[k] = d[3:0];
      for (int c = 0; c < n; c++)
        for (int s = 0; s < 16; s++) begin
          if (m[k][c] && d[3:0] == 4'(s)) begin
            exp_p[k][c][s] = 1'b1;
            exp_s[k][c][s] = re;
          end else if (ce && cc == 3'(c) && cs == 4'(s) && exp_s[k][c][s] == csr) begin
            exp_p[k][c][s] = 1'b0;
          end
        end
    end
    @(negedge clk);
    wr_en = 1'b0; clr_en = 1'b0;
    compare_all(m[0], m[1], tag);
  endtask

  function automatic logic [31:0] mk(logic [1:0] f, logic [7:0] mask, logic [3:0] num);
    return {6'd0, f, mask, 12'd0, num};
  endfunction

  initial begin
    #4000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      exp_id[k] = '0;
      for (int c = 0; c < 8; c++)
        for (int s = 0; s < 16; s++) begin
          exp_p[k][c][s] = 1'b0;
          exp_s[k][c][s] = 3'd0;
        end
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(8'd0, 8'd0, "R1");

    step(1, mk(2'd0, 8'h01, 4'd5) | 32'h3F0, 3'd1, 0, 0, 0, 0, "R2");
    step(1, mk(2'd0, 8'hFF, 4'd9), 3'd3, 0, 0, 0, 0, "R3");
    step(1, mk(2'd1, 8'h00, 4'd2), 3'd2, 0, 0, 0, 0, "R4");
    step(1, mk(2'd2, 8'h00, 4'd7), 3'd3, 0, 0, 0, 0, "R5");
    step(1, mk(2'd2, 8'h00, 4'd8), 3'd6, 0, 0, 0, 0, "R5");
    step(1, mk(2'd3, 8'hFF, 4'd1), 3'd0, 0, 0, 0, 0, "R6");
    step(1, mk(2'd0, 8'hF0, 4'd4), 3'd0, 0, 0, 0, 0, "R8");
    step(1, mk(2'd2, 8'h00, 4'd11), 3'd5, 0, 0, 0, 0, "R9");
    step(0, mk(2'd0, 8'hFF, 4'd3), 3'd0, 0, 0, 0, 0, "R11");
    step(0, 32'd0, 3'd0, 1, 3'd0, 4'd9, 3'd2, "R10");
    step(0, 32'd0, 3'd0, 1, 3'd0, 4'd9, 3'd3, "R10");
    step(1, mk(2'd0, 8'h02, 4'd12), 3'd0, 1, 3'd1, 4'd12, 3'd0, "R10");
    step(1, mk(2'd0, 8'h02, 4'd12), 3'd1, 1, 3'd1, 4'd12, 3'd0, "R10");
    step(0, 32'd0, 3'd0, 1, 3'd6, 4'd0, 3'd0, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      logic [2:0] r = 3'($urandom % 5);
      bit we = ($urandom % 4) != 0;
      bit ce = ($urandom % 2) != 0;
      step(we, d, r, ce, 3'($urandom % 5), 4'($urandom), 3'($urandom % 5), "R7");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule